// File: doc/BRIEF.md
# Serial Channel Controller

One channel of a memory-mapped master for a serial peripheral bus. Software first selects one of up to `NUM_DEV` devices and a serial clock rate through a control/status word. It then starts a transfer through a command word. An immediate transfer moves 1, 2 or 4 bytes through a 32-bit data register. The data sits in the top bytes of that register, and the direction is read, write or full-duplex exchange. A block read instead streams received words to memory through a write-out port, in bursts of `BURST_WORDS` words.

The serial side uses clock-idle-low framing, most significant bit first. Output data changes after each falling clock edge and input data is sampled on each rising edge. The start bit in the command word reads 1 until the transfer has finished, so software polls it. While that bit is 1, all register writes are dropped.

Top module: `sch_chan`

Register offsets on `reg_addr`:
- 0: control/status. Bits [NUM_DEV-1:0] hold the device select. Bits [8+:CODE_W] hold the rate code. Bit 16 is the error flag, which is read-only.
- 1: command. Bit 0 is start, bit 1 is block mode, bits [3:2] are the direction and bits [5:4] are the length code.
- 2: data.
- 3: memory address.
- 4: byte count.

## Requirements
- R1: After reset, `cs_n` is all ones, `sclk`, `mosi` and `dma_valid` are 0, and offsets 0 and 1 read back 0.
- R2: `cs_n` is the inverse of the select field. A control write whose select value has more than one bit set leaves the previous select in place.
- R3: `sclk` idles low. Each of its high and low phases lasts 2^code cycles of `clk`, where code is the rate field.
- R4: The start bit reads 1 from the write that starts a transfer until the transfer completes, and then reads 0.
- R5: Bits go out and come in most significant first. `mosi` changes only while `sclk` is low, and `miso` is captured on the rising edge of `sclk`.
- R6: Length codes 0, 1 and 3 move 1, 2 and 4 bytes (8, 16 and 32 `sclk` pulses). Length code 2, or direction code 3, sets the error flag and starts nothing.
- R7: Immediate transmit data comes from the top bytes of the data register. Received data lands in those same top bytes, with the lower bits cleared. A write-direction transfer (code 1) leaves the data register unchanged.
- R8: In read direction (code 0) and in block mode, `mosi` stays 0.
- R9: Exchange direction (code 2) transmits the data register and replaces it with the received bytes in the same transfer.
- R10: Block mode reads byte-count bytes. Each 32 received bytes leave as `BURST_WORDS` words on consecutive `dma_valid` cycles. The addresses start at the memory address and step by 4.
- R11: In block mode, a memory address or byte count that is not a multiple of 32, or a byte count of 0, sets the error flag and starts nothing. The next start that is accepted clears the flag.
- R12: While the start bit reads 1, writes to every register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cs_n | output | NUM_DEV | Active-low device selects |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| dma_valid | output | 1 | Memory write word valid |
| dma_addr | output | AW | Memory write byte address |
| dma_data | output | 32 | Memory write word |

## Verification
The bench builds the block with its defaults: three devices, a 3-bit rate code and 8-word bursts. With these values it can select each device and try a select with two bits set. It can run rate codes 0, 2 and 3, which makes both the phase length and a long busy window for the ignored writes observable. A 64-byte block read yields two bursts, so the address step across a burst boundary is checked as well as the step within a burst.

// File: rtl/sch_pkg.sv
// Shared definitions for the serial channel: register offsets, field
// positions and the direction encoding. Assumes a 32-bit register bus.
package sch_pkg;
    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_CMD   = 3'd1,
        RA_DATA  = 3'd2,
        RA_ADDR  = 3'd3,
        RA_COUNT = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        DIR_RX   = 2'd0,
        DIR_TX   = 2'd1,
        DIR_XCHG = 2'd2,
        DIR_BAD  = 2'd3
    } dir_e;

    localparam int CODE_LSB = 8;
    localparam int ERR_BIT  = 16;
    localparam int GO_BIT   = 0;
    localparam int BLK_BIT  = 1;
    localparam int DIR_LSB  = 2;
    localparam int LEN_LSB  = 4;
    localparam logic [1:0] LEN_BAD = 2'd2;
endpackage

// File: rtl/sch_clkdiv.sv
// Half-period tick generator. While en is high it pulses tick once every
// 2^code cycles; while en is low the count is held at zero so the first
// tick arrives a full half period after enabling.
module sch_clkdiv #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((32'd1 << code) - 32'd1);
    assign tick  = en && (cnt_q == limit);

    // Count cycles within a half period, restarting on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sch_shifter.sv
// Clock-idle-low serial shifter, most significant bit first. The word is
// loaded on start; each rising tick samples miso, each falling tick shifts.
// After nbits bits, rx_word holds the received bits left-justified.
// Assumes start is only honoured while idle.
module sch_shifter #(
    parameter int DW = 32,
    localparam int CW = $clog2(DW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] nbits,
    input  logic [DW-1:0] tx_word,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic          sclk,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    logic          busy_q, sclk_q, smp_q, done_q;
    logic [CW-1:0] cnt_q, len_q;
    logic [DW-1:0] sh_q;

    // Run the edge sequence and the bit count of one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            smp_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            len_q  <= '0;
            sh_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                sclk_q <= 1'b0;
                sh_q   <= tx_word;
                cnt_q  <= nbits;
                len_q  <= nbits;
            end else if (busy_q && tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    smp_q  <= miso;
                end else begin
                    sclk_q <= 1'b0;
                    sh_q   <= {sh_q[DW-2:0], smp_q};
                    cnt_q  <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign sclk    = sclk_q;
    assign mosi    = busy_q & sh_q[DW-1];
    assign rx_word = sh_q << (CW'(DW) - len_q);
endmodule

// File: rtl/sch_chan.sv
// One channel of a register-driven serial bus master. It holds the register
// file, validates start requests, runs immediate transfers through the data
// register and block reads into BURST_WORDS-word memory bursts. Assumes the
// bus issues at most one register access per cycle; reads are combinational.
module sch_chan
    import sch_pkg::*;
#(
    parameter int NUM_DEV     = 3,
    parameter int CODE_W      = 3,
    parameter int AW          = 32,
    parameter int BURST_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               dma_valid,
    output logic [AW-1:0]      dma_addr,
    output logic [31:0]        dma_data
);
    localparam int DW          = 32;
    localparam int SH_CW       = $clog2(DW) + 1;
    localparam int BURST_BYTES = BURST_WORDS * 4;
    localparam int ALIGN       = $clog2(BURST_BYTES);
    localparam int WI_W        = $clog2(BURST_WORDS);
    localparam logic [WI_W-1:0] LAST_W = WI_W'(BURST_WORDS - 1);

    logic [NUM_DEV-1:0] sel_q;
    logic [CODE_W-1:0]  code_q;
    logic               err_q, go_q, blk_q, sh_start_q, out_q;
    dir_e               dir_q;
    logic [1:0]         len_q;
    logic [DW-1:0]      data_q, count_q, left_q;
    logic [AW-1:0]      mar_q, base_q;
    logic [WI_W-1:0]    wr_idx_q, out_idx_q;
    logic [DW-1:0]      buf_q [BURST_WORDS];

    logic               wr_ok, cmd_go, bad_cmd, tick, sh_busy, sh_done;
    logic [NUM_DEV-1:0] w_sel;
    dir_e               w_dir;
    logic [1:0]         w_len;
    logic               w_blk;
    logic [SH_CW-1:0]   nbits;
    logic [DW-1:0]      tx_word, rx_word;

    assign wr_ok   = reg_wr && !go_q;
    assign w_sel   = reg_wdata[NUM_DEV-1:0];
    assign w_dir   = dir_e'(reg_wdata[DIR_LSB +: 2]);
    assign w_len   = reg_wdata[LEN_LSB +: 2];
    assign w_blk   = reg_wdata[BLK_BIT];
    assign cmd_go  = wr_ok && (reg_addr == RA_CMD) && reg_wdata[GO_BIT];
    assign bad_cmd = (w_dir == DIR_BAD) ||
                     (w_blk ? ((mar_q[ALIGN-1:0] != '0) ||
                               (count_q[ALIGN-1:0] != '0) || (count_q == '0))
                            : (w_len == LEN_BAD));

    assign nbits   = blk_q ? SH_CW'(DW) : SH_CW'({len_q, 3'b000}) + SH_CW'(8);
    assign tx_word = (blk_q || dir_q == DIR_RX) ? '0 : data_q;

    sch_clkdiv #(.CODE_W(CODE_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (sh_busy),
        .code (code_q),
        .tick (tick)
    );

    sch_shifter #(.DW(DW)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start_q),
        .nbits  (nbits),
        .tx_word(tx_word),
        .tick   (tick),
        .miso   (miso),
        .busy   (sh_busy),
        .done   (sh_done),
        .sclk   (sclk),
        .mosi   (mosi),
        .rx_word(rx_word)
    );

    // Software-visible configuration and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            code_q  <= '0;
            blk_q   <= 1'b0;
            dir_q   <= DIR_RX;
            len_q   <= '0;
            data_q  <= '0;
            mar_q   <= '0;
            count_q <= '0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    RA_CTRL: begin
                        code_q <= reg_wdata[CODE_LSB +: CODE_W];
                        if ((w_sel & (w_sel - 1'b1)) == '0) sel_q <= w_sel;
                    end
                    RA_CMD: begin
                        blk_q <= w_blk;
                        dir_q <= w_dir;
                        len_q <= w_len;
                    end
                    RA_DATA:  data_q  <= reg_wdata;
                    RA_ADDR:  mar_q   <= AW'(reg_wdata);
                    RA_COUNT: count_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (sh_done && !blk_q && dir_q != DIR_TX) data_q <= rx_word;
        end
    end

    // Start/busy, error flag and block-read sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q       <= 1'b0;
            err_q      <= 1'b0;
            sh_start_q <= 1'b0;
            out_q      <= 1'b0;
            base_q     <= '0;
            left_q     <= '0;
            wr_idx_q   <= '0;
            out_idx_q  <= '0;
        end else begin
            sh_start_q <= 1'b0;
            if (cmd_go) begin
                if (bad_cmd) begin
                    err_q <= 1'b1;
                end else begin
                    err_q      <= 1'b0;
                    go_q       <= 1'b1;
                    sh_start_q <= 1'b1;
                    base_q     <= mar_q;
                    left_q     <= count_q;
                    wr_idx_q   <= '0;
                end
            end
            if (sh_done && go_q) begin
                if (!blk_q) begin
                    go_q <= 1'b0;
                end else if (wr_idx_q == LAST_W) begin
                    wr_idx_q  <= '0;
                    out_q     <= 1'b1;
                    out_idx_q <= '0;
                    left_q    <= left_q - DW'(BURST_BYTES);
                    if (left_q != DW'(BURST_BYTES)) sh_start_q <= 1'b1;
                end else begin
                    wr_idx_q   <= wr_idx_q + 1'b1;
                    sh_start_q <= 1'b1;
                end
            end
            if (out_q) begin
                out_idx_q <= out_idx_q + 1'b1;
                if (out_idx_q == LAST_W) begin
                    out_q  <= 1'b0;
                    base_q <= base_q + AW'(BURST_BYTES);
                    if (left_q == '0) go_q <= 1'b0;
                end
            end
        end
    end

    // Collect received words of the current burst.
    always_ff @(posedge clk) begin
        if (sh_done && go_q && blk_q) buf_q[wr_idx_q] <= rx_word;
    end

    // Register read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata = 32'(sel_q) | (32'(code_q) << CODE_LSB) |
                                  (32'(err_q) << ERR_BIT);
            RA_CMD:   reg_rdata = (32'(go_q) << GO_BIT) | (32'(blk_q) << BLK_BIT) |
                                  (32'(dir_q) << DIR_LSB) | (32'(len_q) << LEN_LSB);
            RA_DATA:  reg_rdata = data_q;
            RA_ADDR:  reg_rdata = 32'(mar_q);
            RA_COUNT: reg_rdata = count_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign cs_n      = ~sel_q;
    assign dma_valid = out_q;
    assign dma_addr  = base_q + AW'({out_idx_q, 2'b00});
    assign dma_data  = buf_q[out_idx_q];
endmodule

// File: rtl/sch_chan_checker.sv
// Temporal checks on the serial channel, attached by bind. Assumes the
// default one-hot select discipline and 32-byte alignment of bursts.
module sch_chan_checker #(
    parameter int NUM_DEV     = 3,
    parameter int AW          = 32,
    parameter int BURST_WORDS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               sclk,
    input logic               mosi,
    input logic               dma_valid,
    input logic [AW-1:0]      dma_addr,
    input logic               go,
    input logic               err,
    input logic               blk,
    input logic [1:0]         dir,
    input logic [AW-1:0]      mar
);
    localparam int ALIGN = $clog2(BURST_WORDS * 4);
    localparam int RUN_W = $clog2(BURST_WORDS) + 2;

    logic [RUN_W-1:0] run_q;

    // Length of the current run of valid burst cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (dma_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> !sclk);
    p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    p_rx_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (blk || dir == 2'd0)) |-> !mosi);
    p_burst_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !$past(dma_valid)) |-> (dma_addr[ALIGN-1:0] == '0));
    p_burst_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_valid) |-> (run_q == RUN_W'(BURST_WORDS)));
    p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !go);
    p_mar_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go)) |-> $stable(mar));
endmodule

bind sch_chan sch_chan_checker #(
    .NUM_DEV(NUM_DEV), .AW(AW), .BURST_WORDS(BURST_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .dma_valid(dma_valid),
    .dma_addr (dma_addr),
    .go       (go_q),
    .err      (err_q),
    .blk      (blk_q),
    .dir      (dir_q),
    .mar      (mar_q)
);

// File: tb/sch_chan_bench.sv
module sch_chan_bench;
    typedef struct packed {
        logic [1:0]  dir;
        logic [1:0]  len;
        logic [31:0] tx;
        logic [31:0] resp;
        logic [31:0] exp_data;
        logic [31:0] exp_mosi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 2'd0, 32'hA5000000, 32'hFFFFFFFF, 32'hA5000000, 32'hA5000000},
        '{2'd0, 2'd1, 32'h12345678, 32'hBEEF0000, 32'hBEEF0000, 32'h00000000},
        '{2'd2, 2'd3, 32'hCAFEF00D, 32'h13579BDF, 32'h13579BDF, 32'hCAFEF00D},
        '{2'd2, 2'd0, 32'h3C000000, 32'h81000000, 32'h81000000, 32'h3C000000},
        '{2'd0, 2'd3, 32'h00000000, 32'h0F1E2D3C, 32'h0F1E2D3C, 32'h00000000},
        '{2'd2, 2'd1, 32'hFFFF1234, 32'h00017777, 32'h00010000, 32'hFFFF0000}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [2:0]  cs_n;
    logic        sclk, mosi, miso, dma_valid;
    logic [31:0] dma_addr, dma_data;

    int n_total = 0, n_fail = 0;
    logic [31:0] resp_word = '0;

    always #2 clk = ~clk;

    sch_chan u_sch_chan (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso), .dma_valid(dma_valid),
        .dma_addr(dma_addr), .dma_data(dma_data)
    );

    // Device responder: presents resp_word MSB first, advancing on falling sclk.
    wire cs_idle = &cs_n;
    logic [4:0] ridx = '0;
    always @(negedge sclk or posedge cs_idle)
        if (cs_idle) ridx <= '0; else ridx <= ridx + 1'b1;
    assign miso = resp_word[5'd31 - ridx];

    // Capture of transmitted bits on rising sclk.
    logic [31:0] cap = '0;
    always @(posedge sclk) cap <= {cap[30:0], mosi};

    // Port monitor: phase length, pulse count, mode-0 rule and burst log.
    int cyc = 0, hi_run = 0, last_high = 0, rises = 0, dma_n = 0;
    bit mode0_bad = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    int          log_cyc  [16];
    always @(negedge clk) begin
        cyc++;
        if (sclk === 1'b1) begin
            hi_run++;
            if (prev_sclk === 1'b0) rises++;
            if (prev_sclk === 1'b1 && mosi !== prev_mosi) mode0_bad = 1;
        end else if (hi_run != 0) begin
            last_high = hi_run;
            hi_run = 0;
        end
        if (dma_valid === 1'b1) begin
            if (dma_n < 16) begin
                log_addr[dma_n] = dma_addr;
                log_data[dma_n] = dma_data;
                log_cyc[dma_n]  = cyc;
            end
            dma_n++;
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle;
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd1, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0, n0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(cs_n == 3'b111, "R1 cs_n", 32'(cs_n), 32'h7);
        check(!sclk && !mosi && !dma_valid, "R1 serial idle",
              {29'd0, sclk, mosi, dma_valid}, 32'd0);
        rd(3'd0, v); check(v == 0, "R1 ctrl", v, 0);
        rd(3'd1, v); check(v == 0, "R1 cmd", v, 0);

        // R2: one-hot select and rejection of multi-bit select
        wr(3'd0, 32'h4);
        @(negedge clk); check(cs_n == 3'b011, "R2 select dev2", 32'(cs_n), 32'h3);
        wr(3'd0, 32'h3);
        @(negedge clk); check(cs_n == 3'b011, "R2 multi-bit ignored", 32'(cs_n), 32'h3);
        wr(3'd0, 32'h0);

        // Vector table: immediate transfers at rate code 0 on device 0
        for (int k = 0; k < NV; k++) begin
            int nb;
            logic [31:0 ] capj;
            nb = (int'(VEC[k].len) + 1) * 8;
            resp_word = VEC[k].resp;
            wr(3'd0, 32'h1);
            wr(3'd2, VEC[k].tx);
            r0 = rises;
            wr(3'd1, 32'h1 | (32'(VEC[k].dir) << 2) | (32'(VEC[k].len) << 4));
            rd(3'd1, v); check(v[0] == 1'b1, "R4 busy during transfer", v, 1);
            wait_idle();
            rd(3'd1, v); check(v[0] == 1'b0, "R4 start clears", v, 0);
            check(rises - r0 == nb, "R6 pulse count", 32'(rises - r0), 32'(nb));
            rd(3'd2, v); check(v == VEC[k].exp_data, "R7 R9 data register", v, VEC[k].exp_data);
            capj = cap << (32 - nb);
            check(capj == VEC[k].exp_mosi, "R5 R8 transmitted bits", capj, VEC[k].exp_mosi);
            wr(3'd0, 32'h0);
        end
        check(!mode0_bad, "R5 mosi changed while sclk high", 32'(mode0_bad), 0);
        check(last_high == 1, "R3 phase at code 0", 32'(last_high), 1);

        // R3: rate code 2 gives 4-cycle phases
        resp_word = 32'h0;
        wr(3'd0, 32'h201);
        wr(3'd1, 32'h1 | (32'd2 << 2));
        wait_idle();
        check(last_high == 4, "R3 phase at code 2", 32'(last_high), 4);
        wr(3'd0, 32'h0);

        // R6: illegal length code and direction code
        r0 = rises;
        wr(3'd1, 32'h1 | (32'd2 << 4));
        rd(3'd1, v); check(v[0] == 1'b0, "R6 len code 2 no start", v, 0);
        rd(3'd0, v); check(v[16] == 1'b1, "R6 len code 2 error", v, 32'h10000);
        wr(3'd1, 32'h1 | (32'd3 << 2));
        rd(3'd1, v); check(v[0] == 1'b0, "R6 dir code 3 no start", v, 0);
        check(rises == r0, "R6 no pulses", 32'(rises - r0), 0);

        // R11: misaligned block requests
        n0 = dma_n;
        wr(3'd3, 32'h104); wr(3'd4, 32'd64); wr(3'd1, 32'h3);
        rd(3'd1, v); check(v[0] == 1'b0, "R11 address misaligned", v, 0);
        wr(3'd3, 32'h100); wr(3'd4, 32'd48); wr(3'd1, 32'h3);
        rd(3'd1, v); check(v[0] == 1'b0, "R11 count misaligned", v, 0);
        wr(3'd4, 32'd0); wr(3'd1, 32'h3);
        rd(3'd0, v); check(v[16] == 1'b1, "R11 zero count error", v, 32'h10000);
        check(dma_n == n0, "R11 no burst", 32'(dma_n - n0), 0);

        // R10: 64-byte block read as two bursts
        resp_word = 32'hA1B2C3D4;
        wr(3'd0, 32'h2);
        wr(3'd4, 32'd64);
        wr(3'd1, 32'h3);
        rd(3'd0, v); check(v[16] == 1'b0, "R11 error cleared by start", v, 0);
        wait_idle();
        check(dma_n - n0 == 16, "R10 word count", 32'(dma_n - n0), 16);
        for (int w = 0; w < 16; w++) begin
            check(log_addr[w] == 32'h100 + 32'(4 * w), "R10 word address",
                  log_addr[w], 32'h100 + 32'(4 * w));
            check(log_data[w] == 32'hA1B2C3D4, "R10 word data", log_data[w], 32'hA1B2C3D4);
            if (w % 8 != 0)
                check(log_cyc[w] == log_cyc[w-1] + 1, "R10 consecutive burst",
                      32'(log_cyc[w]), 32'(log_cyc[w-1] + 1));
        end
        wr(3'd0, 32'h0);

        // R12: writes while busy are dropped
        resp_word = 32'h96000000;
        wr(3'd0, 32'h301);
        wr(3'd2, 32'h5A000000);
        r0 = rises;
        wr(3'd1, 32'h1 | (32'd2 << 2));
        wr(3'd2, 32'hFFFFFFFF);
        wr(3'd3, 32'h40);
        wr(3'd0, 32'h4);
        wr(3'd1, 32'h1 | (32'd1 << 2) | (32'd3 << 4));
        check(cs_n == 3'b110, "R12 select held", 32'(cs_n), 32'h6);
        rd(3'd0, v); check(v == 32'h301, "R12 ctrl held", v, 32'h301);
        wait_idle();
        rd(3'd2, v); check(v == 32'h96000000, "R12 data from transfer", v, 32'h96000000);
        rd(3'd3, v); check(v == 32'h100, "R12 address held", v, 32'h100);
        check(rises - r0 == 8, "R12 no second transfer", 32'(rises - r0), 8);
        wr(3'd0, 32'h0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule